// File: doc/BRIEF.md
# Four-Line Fully Associative Read Cache

This block is a small word cache placed between a processor-side port that moves one word at a time and a main-memory port that moves whole lines. It holds four lines of four words each. The line address of every resident line sits in a tag store that is searched by content: each request's tag is compared against all four stored tags in the same cycle. Any line can therefore hold any memory line.

A read that finds its line returns the word straight from local storage in the cycle of the request. A read that misses starts a line refill. The four words of the aligned line come back from memory lowest offset first. The requested word goes to the processor in the very cycle its beat arrives, and all four beats are written into a line picked by hardware. Writes go through to memory. A write also updates the resident copy if the line is present, and a write that misses leaves the cache contents alone. Two counters expose cache-served reads and main-memory transactions, so that a testbench can derive the hit rate as cache reads over all accesses.

Top module: `assoc_cache`

## Requirements
- R1: After reset every line is invalid, `hit_count` and `mem_count` are zero, and `cpu_ready` and `mem_req` are low.
- R2: A read whose tag (address bits above the low 2) matches a valid line raises `cpu_ready` in the same cycle as `cpu_req`, with the addressed word on `cpu_rdata` and `mem_req` low.
- R3: A read miss raises `mem_req` with `mem_we` low from the next cycle on, with `mem_addr` set to the request address with its low 2 bits cleared. It holds `mem_req`, `mem_addr` and `mem_we` steady until four beats have each been taken on a cycle with `mem_ready` high, at offsets 0, 1, 2 and 3 in that order.
- R4: On a read miss, `cpu_ready` is high in exactly one cycle: the one whose memory beat carries the requested offset `cpu_addr[1:0]`. In that cycle `cpu_rdata` equals that beat's data. It is low in the lookup cycle.
- R5: While a refill is in progress, `cpu_ready` stays low for any request. A request presented in the cycle right after the last beat is accepted.
- R6: The line filled on a miss is the lowest-numbered invalid line if one exists. Otherwise it is the line named by a 2-bit round-robin pointer, which resets to 0 and advances by one (wrapping 3 to 0) after every fill.
- R7: A write takes one lookup cycle, then holds `mem_req` and `mem_we` high with `mem_addr` equal to the write address and `mem_wdata` equal to the write data. `cpu_ready` rises in the cycle `mem_ready` is high. A resident copy of the word takes the new data, and a write miss allocates no line.
- R8: `hit_count` rises by one for each read hit. `mem_count` rises by one for each read miss and for each write. The two counters never both change in the same cycle.
- R9: At most one line matches a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completed this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` on a read |
| mem_req | output | 1 | Memory transaction active |
| mem_we | output | 1 | 1 = single-word write, 0 = four-beat line read |
| mem_addr | output | ADDR_W | Line base (read) or word address (write) |
| mem_wdata | output | DATA_W | Write-through data |
| mem_ready | input | 1 | Memory accepts the write or delivers one beat this cycle |
| mem_rdata | input | DATA_W | Beat data |
| hit_count | output | CNT_W | Reads served from the cache |
| mem_count | output | CNT_W | Main-memory transactions |

## Verification
The hardest case to reach is the round-robin replacement. It only comes into play once all four lines are valid, and it shows at the ports only through which later reads hit. The stimulus first fills the four lines with distinct tags. It then issues conflicting misses and re-reads the evicted and surviving lines, while a behavioural model predicts each hit or miss. The refill tail is stressed as well: misses at low offsets leave beats outstanding after the word is delivered, and a probe request is held during those beats. Memory wait states of zero to two cycles move the delivery cycle around.

// File: rtl/assoc_cache_pkg.sv
package assoc_cache_pkg;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_FILL  = 2'd1,
    CS_WRITE = 2'd2
  } cache_state_e;

endpackage

// File: rtl/cache_tag_cam.sv
module cache_tag_cam #(
  parameter int LINES  = 4,
  parameter int TAG_W  = 14,
  parameter int LINE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAG_W-1:0]  look_tag,
  input  logic              set_en,
  input  logic [LINE_W-1:0] set_line,
  input  logic [TAG_W-1:0]  set_tag,
  output logic [LINES-1:0]  match_vec,
  output logic [LINE_W-1:0] match_idx,
  output logic [LINES-1:0]  valid_vec
);

  logic [TAG_W-1:0] tag_q   [LINES];
  logic             valid_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_entry
    logic sel;
    assign sel = set_en && (set_line == LINE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
      end else if (sel) begin
        valid_q[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[g] <= set_tag;
      end
    end

    assign match_vec[g] = valid_q[g] && (tag_q[g] == look_tag);
    assign valid_vec[g] = valid_q[g];
  end

  always_comb begin
    match_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (match_vec[i]) begin
        match_idx = LINE_W'(i);
      end
    end
  end

endmodule

// File: rtl/cache_victim.sv
module cache_victim #(
  parameter int LINES  = 4,
  parameter int LINE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  valid_vec,
  input  logic              advance,
  output logic [LINE_W-1:0] victim
);

  logic [LINE_W-1:0] rr_q, rr_d;
  logic              found;

  always_comb begin
    rr_d = rr_q;
    if (advance) begin
      if (rr_q == LINE_W'(LINES - 1)) begin
        rr_d = '0;
      end else begin
        rr_d = rr_q + LINE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (advance) begin
      rr_q <= rr_d;
    end
  end

  always_comb begin
    victim = rr_q;
    found  = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      if (!found && !valid_vec[i]) begin
        victim = LINE_W'(i);
        found  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cache_line_store.sv
module cache_line_store #(
  parameter int LINES  = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int LINE_W = 2,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [OFF_W-1:0]  wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LINE_W-1:0] rd_line,
  input  logic [OFF_W-1:0]  rd_word,
  output logic [DATA_W-1:0] rd_data
);

  localparam int ENTRIES = LINES * WORDS;

  logic [DATA_W-1:0] store_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store_q[{wr_line, wr_word}] <= wr_data;
    end
  end

  assign rd_data = store_q[{rd_line, rd_word}];

endmodule

// File: rtl/assoc_cache.sv
module assoc_cache
  import assoc_cache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 4,
  parameter int WORDS  = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  mem_count
);

  localparam int OFF_W  = $clog2(WORDS);
  localparam int LINE_W = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFF_W;

  // request fields
  logic [TAG_W-1:0] req_tag;
  logic [OFF_W-1:0] req_off;
  assign req_tag = cpu_addr[ADDR_W-1:OFF_W];
  assign req_off = cpu_addr[OFF_W-1:0];

  // state and datapath registers
  cache_state_e      state_q, state_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [OFF_W-1:0]  beat_q, beat_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic [ADDR_W-1:0] waddr_q, waddr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [CNT_W-1:0]  hitc_q, hitc_d;
  logic [CNT_W-1:0]  memc_q, memc_d;
  logic              ctl_en, dp_en, cnt_en;

  // sub-block wiring
  logic [LINES-1:0]  cam_match;
  logic [LINE_W-1:0] cam_idx;
  logic [LINES-1:0]  cam_valid;
  logic              cam_hit;
  logic              cam_set;
  logic [LINE_W-1:0] victim;
  logic              vic_adv;
  logic              st_we;
  logic [LINE_W-1:0] st_line;
  logic [OFF_W-1:0]  st_word;
  logic [DATA_W-1:0] st_data;
  logic [DATA_W-1:0] st_rdata;

  assign cam_hit = |cam_match;

  cache_tag_cam #(
    .LINES (LINES),
    .TAG_W (TAG_W),
    .LINE_W(LINE_W)
  ) u_cam (
    .clk      (clk),
    .rst_n    (rst_n),
    .look_tag (req_tag),
    .set_en   (cam_set),
    .set_line (line_q),
    .set_tag  (tag_q),
    .match_vec(cam_match),
    .match_idx(cam_idx),
    .valid_vec(cam_valid)
  );

  cache_victim #(
    .LINES (LINES),
    .LINE_W(LINE_W)
  ) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_vec(cam_valid),
    .advance  (vic_adv),
    .victim   (victim)
  );

  cache_line_store #(
    .LINES (LINES),
    .WORDS (WORDS),
    .DATA_W(DATA_W),
    .LINE_W(LINE_W),
    .OFF_W (OFF_W)
  ) u_store (
    .clk    (clk),
    .wr_en  (st_we),
    .wr_line(st_line),
    .wr_word(st_word),
    .wr_data(st_data),
    .rd_line(cam_idx),
    .rd_word(req_off),
    .rd_data(st_rdata)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    tag_d     = tag_q;
    off_d     = off_q;
    beat_d    = beat_q;
    line_d    = line_q;
    waddr_d   = waddr_q;
    wdata_d   = wdata_q;
    hitc_d    = hitc_q;
    memc_d    = memc_q;
    st_we     = 1'b0;
    st_line   = line_q;
    st_word   = beat_q;
    st_data   = mem_rdata;
    cam_set   = 1'b0;
    vic_adv   = 1'b0;
    cpu_ready = 1'b0;
    cpu_rdata = mem_rdata;

    case (state_q)
      CS_IDLE: begin
        cpu_rdata = st_rdata;
        if (cpu_req) begin
          if (cpu_we) begin
            state_d = CS_WRITE;
            waddr_d = cpu_addr;
            wdata_d = cpu_wdata;
            memc_d  = memc_q + CNT_W'(1);
            if (cam_hit) begin
              st_we   = 1'b1;
              st_line = cam_idx;
              st_word = req_off;
              st_data = cpu_wdata;
            end
          end else if (cam_hit) begin
            cpu_ready = 1'b1;
            hitc_d    = hitc_q + CNT_W'(1);
          end else begin
            state_d = CS_FILL;
            tag_d   = req_tag;
            off_d   = req_off;
            beat_d  = '0;
            line_d  = victim;
            memc_d  = memc_q + CNT_W'(1);
          end
        end
      end
      CS_FILL: begin
        if (mem_ready) begin
          st_we     = 1'b1;
          cpu_ready = (beat_q == off_q);
          beat_d    = beat_q + OFF_W'(1);
          if (beat_q == OFF_W'(WORDS - 1)) begin
            cam_set = 1'b1;
            vic_adv = 1'b1;
            state_d = CS_IDLE;
          end
        end
      end
      CS_WRITE: begin
        if (mem_ready) begin
          cpu_ready = 1'b1;
          state_d   = CS_IDLE;
        end
      end
      default: state_d = CS_IDLE;
    endcase
  end

  // clock enables
  assign ctl_en = (state_q != CS_IDLE) || cpu_req;
  assign dp_en  = (state_q == CS_IDLE) && cpu_req;
  assign cnt_en = (state_q == CS_IDLE) && cpu_req;

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      beat_q  <= '0;
    end else if (ctl_en) begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hitc_q <= '0;
      memc_q <= '0;
    end else if (cnt_en) begin
      hitc_q <= hitc_d;
      memc_q <= memc_d;
    end
  end

  // datapath registers, no reset
  always_ff @(posedge clk) begin
    if (dp_en) begin
      tag_q   <= tag_d;
      off_q   <= off_d;
      line_q  <= line_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
    end
  end

  // memory side
  assign mem_req   = (state_q != CS_IDLE);
  assign mem_we    = (state_q == CS_WRITE);
  assign mem_addr  = (state_q == CS_WRITE) ? waddr_q : {tag_q, {OFF_W{1'b0}}};
  assign mem_wdata = wdata_q;

  assign hit_count = hitc_q;
  assign mem_count = memc_q;

endmodule

// File: rtl/assoc_cache_chk.sv
module assoc_cache_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int LINES  = 4,
  parameter int OFF_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  mem_count,
  input logic [LINES-1:0]  cam_match
);

  assert_single_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cam_match));

  assert_line_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr[OFF_W-1:0] == '0));

  assert_mem_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));

  assert_no_ready_without_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |-> !cpu_ready);

  assert_hit_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count == $past(hit_count)) || (hit_count == $past(hit_count) + CNT_W'(1)));

  assert_counters_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !((hit_count != $past(hit_count)) && (mem_count != $past(mem_count))));

endmodule

bind assoc_cache assoc_cache_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .CNT_W (CNT_W),
  .LINES (LINES),
  .OFF_W (OFF_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_ready(cpu_ready),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_ready(mem_ready),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .hit_count(hit_count),
  .mem_count(mem_count),
  .cam_match(cam_match)
);

// File: tb/assoc_cache_tb.sv
`timescale 1ns/1ps
module assoc_cache_tb;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_req, cpu_we;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ready;
  logic [DW-1:0] mem_rdata;
  logic [CW-1:0] hit_count, mem_count;

  always #2 clk = ~clk;

  assoc_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .hit_count(hit_count), .mem_count(mem_count)
  );

  // behavioural memory and cache model
  logic [DW-1:0] mem_m [256];
  logic [13:0]   ref_tag [4];
  bit            ref_val [4];
  int            ref_rr;
  int            ref_hits, ref_mem;
  int            gap;
  int            rsp_beat, rsp_wait;
  int            n_chk, n_err;
  bit            finished;

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", what, act, exp, $time);
    end
  endtask

  function automatic int ref_find(input logic [13:0] t);
    for (int i = 0; i < 4; i++) if (ref_val[i] && ref_tag[i] == t) return i;
    return -1;
  endfunction

  function automatic void ref_fill(input logic [13:0] t);
    int v = -1;
    for (int i = 0; i < 4; i++) if (!ref_val[i] && v < 0) v = i;
    if (v < 0) v = ref_rr;
    ref_tag[v] = t;
    ref_val[v] = 1'b1;
    ref_rr = (ref_rr + 1) % 4;
  endfunction

  // memory responder: decides mem_ready for the coming edge
  always @(negedge clk) begin
    if (!mem_req) begin
      mem_ready = 1'b0;
      rsp_beat  = 0;
      rsp_wait  = gap;
    end else if (rsp_wait > 0) begin
      mem_ready = 1'b0;
      rsp_wait--;
    end else begin
      mem_ready = 1'b1;
      mem_rdata = mem_m[(int'(mem_addr[7:0]) + rsp_beat) % 256];
      rsp_beat++;
      rsp_wait  = gap;
    end
  end

  task automatic rd(input logic [AW-1:0] a, input string tag);
    int            li;
    int            off;
    logic [DW-1:0] exp;
    bit            done, delivered, exp_r;
    li  = ref_find(a[15:2]);
    off = int'(a[1:0]);
    exp = mem_m[a[7:0]];
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    #1;
    if (li >= 0) begin
      chk(cpu_ready === 1'b1, {tag, " R2 hit ready"}, DW'(cpu_ready), 1);
      chk(mem_req === 1'b0, {tag, " R2 no mem on hit"}, DW'(mem_req), 0);
      chk(cpu_rdata === exp, {tag, " R2 hit data"}, cpu_rdata, exp);
      ref_hits++;
    end else begin
      chk(cpu_ready === 1'b0, {tag, " R4 no ready in lookup"}, DW'(cpu_ready), 0);
      delivered = 1'b0;
      done      = 1'b0;
      while (!done) begin
        @(negedge clk);
        if (delivered) cpu_addr = a ^ 16'h0044;
        #1;
        chk(mem_req === 1'b1 && mem_we === 1'b0 && mem_addr === {a[15:2], 2'b00},
            {tag, " R3 fill request"}, DW'(mem_addr), DW'({a[15:2], 2'b00}));
        exp_r = mem_ready && !delivered && (rsp_beat - 1 == off);
        chk(cpu_ready === exp_r, {tag, " R4/R5 ready timing"}, DW'(cpu_ready), DW'(exp_r));
        if (exp_r) begin
          chk(cpu_rdata === exp, {tag, " R4 forwarded data"}, cpu_rdata, exp);
          delivered = 1'b1;
        end
        done = mem_ready && (rsp_beat == 4);
      end
      ref_fill(a[15:2]);
      ref_mem++;
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    bit done;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    #1;
    chk(cpu_ready === 1'b0 && mem_req === 1'b0, {tag, " R7 lookup cycle"}, DW'(cpu_ready), 0);
    done = 1'b0;
    while (!done) begin
      @(negedge clk);
      #1;
      chk(mem_req === 1'b1 && mem_we === 1'b1 && mem_addr === a && mem_wdata === d,
          {tag, " R7 write-through"}, mem_wdata, d);
      chk(cpu_ready === mem_ready, {tag, " R7 ready"}, DW'(cpu_ready), DW'(mem_ready));
      done = mem_ready;
    end
    mem_m[a[7:0]] = d;
    ref_mem++;
  endtask

  task automatic idle;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    #1;
  endtask

  task automatic chk_counts(input string tag);
    chk(hit_count === CW'(ref_hits), {tag, " R8 hit_count"}, DW'(hit_count), DW'(ref_hits));
    chk(mem_count === CW'(ref_mem), {tag, " R8 mem_count"}, DW'(mem_count), DW'(ref_mem));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R5 watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    int unsigned seed;
    logic [AW-1:0] ra;
    finished = 1'b0;
    n_chk = 0; n_err = 0;
    ref_rr = 0; ref_hits = 0; ref_mem = 0;
    for (int i = 0; i < 4; i++) begin ref_val[i] = 1'b0; ref_tag[i] = '0; end
    for (int i = 0; i < 256; i++) mem_m[i] = (i * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    gap = 0; rsp_beat = 0; rsp_wait = 0;
    mem_ready = 1'b0; mem_rdata = '0;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h0010; cpu_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state with a request pending
    chk(cpu_ready === 1'b0, "R1 ready in reset", DW'(cpu_ready), 0);
    chk(mem_req === 1'b0, "R1 mem_req in reset", DW'(mem_req), 0);
    cpu_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(hit_count === '0 && mem_count === '0, "R1 counters", DW'(hit_count), 0);

    // first touches: all lines invalid, so misses (R1)
    rd(16'h0010, "R1");
    rd(16'h0013, "R2");       // same line, hit right after fill (R5)
    rd(16'h0011, "R2");
    gap = 2;
    rd(16'h0022, "R4");       // offset 2 with probe during tail
    gap = 1;
    rd(16'h0037, "R4");       // offset 3, last beat
    gap = 0;
    rd(16'h0044, "R6");       // fourth invalid line
    chk_counts("mid");
    // all valid now: round-robin victims
    rd(16'h0050, "R6");
    rd(16'h0023, "R6");       // line of 0x22 must survive
    rd(16'h0011, "R6");       // 0x10 line was evicted
    rd(16'h0021, "R6");
    rd(16'h0046, "R6");
    rd(16'h0052, "R6");
    // write hit then read back, write miss then read
    wr(16'h0046, 32'hCAFE_0046, "R7");
    rd(16'h0046, "R7");
    wr(16'h00C1, 32'hBEEF_00C1, "R7");
    rd(16'h00C1, "R7");       // write miss allocated nothing
    idle();
    chk_counts("directed");

    // mixed traffic
    seed = 32'h1234_5678;
    for (int n = 0; n < 300; n++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      gap  = int'((seed >> 4) % 3);
      ra   = 16'h0080 + AW'((seed >> 8) % 40);
      if (((seed >> 20) % 6) == 0) wr(ra, seed ^ 32'h0F0F_0F0F, "R7");
      else rd(ra, "R6");
    end
    idle();
    chk_counts("final");
    finish_run();
  end

endmodule